// File: doc/BRIEF.md
# NIC interrupt status register block

This block is the control-and-status register file of a Fast Ethernet controller. Software reaches it through a 32-bit read/write port, and the word offset selects one of sixteen register slots. The receive and transmit engines send one-cycle event pulses into it. Each pulse sets a sticky bit in a status word. Software clears those bits by writing ones to the status register.

Two summary bits are rebuilt from fixed groups of event bits every cycle. One summary covers normal events and one covers abnormal events. A level interrupt line is high whenever either summary is set. When the status word is read, it also reports receive and transmit process-state fields. These fields are derived from run-control bits held in an operating-mode register.

The block also holds the following:
- A missed-frame counter. It reads as zero and clears whenever it is read.
- Receive and transmit descriptor list base registers. Each write to one of them also loads the matching current-descriptor pointer.

Top module: `nic_csr_block`

## Requirements
- R1: After a synchronous reset, the following are all zero: the status word, the interrupt line, both descriptor pointers, the missed-frame count and the read data.
- R2: A pulse on `evt_i` sets the status bit at the same position, and the bit stays set until it is cleared. The positions that can be set are 0, 1, 2, 3, 5, 6, 7, 8, 9, 11 and 13; pulses on any other position are ignored. The bit is visible from the clock edge that samples the pulse.
- R3: Status bit 16 (normal summary) is set exactly when at least one of event bits 0, 2 or 6 is set.
- R4: Status bit 15 (abnormal summary) is set exactly when at least one of event bits 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R5: `irq_o` is high exactly when status bit 15 or bit 16 is set, and it changes on the same edge as the status word.
- R6: A write to register index 5 (the status word) clears every event bit where the write data holds a one and leaves the other bits unchanged. Writing bits 15 or 16 has no effect, because both summaries are recomputed.
- R7: If an event pulse and a write-one-to-clear of the same bit arrive in the same cycle, the bit stays set.
- R8: A read of index 5 returns 3 in bits 22:20 when bit 13 of the mode register (index 6) is set, and 0 otherwise. It returns 3 in bits 19:17 when mode bit 1 is set, and 0 otherwise. The mode register reads back as written.
- R9: Each `miss_i` pulse increments `miss_cnt_o`, which saturates at its maximum value. A read of index 8 returns zero and clears the count. A pulse that arrives in the same cycle as that read leaves the count at 1.
- R10: A write to index 3 (receive list base) or index 4 (transmit list base) stores the data and loads `rx_cur_o` or `tx_cur_o` respectively. The stored value reads back at the same index.
- R11: Register index is `addr[6:3]`, and `addr[2:0]` is ignored. Indexes other than 3, 4, 5, 6 and 8 read as zero, and writes to them change nothing.
- R12: `rdata` is registered. It holds the selected value on the cycle after `rd_en` is high and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 7 | Byte offset; bits 6:3 select the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_i | input | 32 | Event pulses, one per status bit position |
| miss_i | input | 1 | Missed-frame pulse |
| irq_o | output | 1 | Level interrupt request |
| rx_cur_o | output | 32 | Current receive descriptor pointer |
| tx_cur_o | output | 32 | Current transmit descriptor pointer |
| miss_cnt_o | output | MISS_W | Missed-frame count |

## Verification
The checker assumes the following about the inputs:
- Event pulses may land on any bit position.
- A read and a write never target the same slot in the same cycle.

The clear property fires only in cycles where no event pulse lands on a bit being cleared. That race is covered by the set property, so the two never conflict.

The stimulus changes every input half a cycle away from the sampling edge. It holds each event and each strobe for exactly one cycle, except for the missed-frame bursts. It never issues a read and a write together.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int CSR_W = 32;

  localparam logic [CSR_W-1:0] EVT_MASK = 32'h0000_2BEF;
  localparam logic [CSR_W-1:0] NRM_MASK = 32'h0000_0045;
  localparam logic [CSR_W-1:0] ABN_MASK = 32'h0000_2BAA;

  localparam int NRM_BIT   = 16;
  localparam int ABN_BIT   = 15;
  localparam int RX_ST_LSB = 17;
  localparam int TX_ST_LSB = 20;

  localparam int SLOT_RXBASE = 3;
  localparam int SLOT_TXBASE = 4;
  localparam int SLOT_STAT   = 5;
  localparam int SLOT_MODE   = 6;
  localparam int SLOT_MISS   = 8;

  localparam int MODE_RUN_RX = 1;
  localparam int MODE_RUN_TX = 13;

  typedef enum logic [2:0] {
    PROC_IDLE = 3'd0,
    PROC_BUSY = 3'd3
  } proc_state_e;

  function automatic proc_state_e proc_state(input logic run);
    return run ? PROC_BUSY : PROC_IDLE;
  endfunction
endpackage

// File: rtl/nic_stat_unit.sv
module nic_stat_unit
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CSR_W-1:0] evt,
  input  logic             clr_en,
  input  logic [CSR_W-1:0] clr_data,
  output logic [CSR_W-1:0] stat_o,
  output logic             irq_o
);
  logic [CSR_W-1:0] ev_q, ev_n, clr_m;
  logic nrm_q, abn_q, irq_q, nrm_n, abn_n;

  always_comb begin
    clr_m = clr_en ? clr_data : '0;
    // set wins over clear for the same bit (R7)
    ev_n  = ((ev_q & ~clr_m) | evt) & EVT_MASK;
    nrm_n = |(ev_n & NRM_MASK);
    abn_n = |(ev_n & ABN_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q  <= '0;
      nrm_q <= 1'b0;
      abn_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ev_q  <= ev_n;
      nrm_q <= nrm_n;
      abn_q <= abn_n;
      irq_q <= nrm_n | abn_n;
    end
  end

  always_comb begin
    stat_o          = ev_q;
    stat_o[NRM_BIT] = nrm_q;
    stat_o[ABN_BIT] = abn_q;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/nic_miss_ctr.sv
module nic_miss_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= inc ? CNT_W'(1) : '0;
    end else if (inc && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nic_ptr_reg.sv
module nic_ptr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] base_o,
  output logic [W-1:0] cur_o
);
  logic [W-1:0] base_q, cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (ld) begin
      base_q <= d;
      cur_q  <= d;
    end
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;
endmodule

// File: rtl/nic_csr_block.sv
module nic_csr_block
  import nic_csr_pkg::*;
#(
  parameter  int NUM_REGS = 16,
  parameter  int OFS_LSB  = 3,
  parameter  int MISS_W   = 16,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int ADDR_W   = IDX_W + OFS_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CSR_W-1:0]  wdata,
  output logic [CSR_W-1:0]  rdata,
  input  logic [CSR_W-1:0]  evt_i,
  input  logic              miss_i,
  output logic              irq_o,
  output logic [CSR_W-1:0]  rx_cur_o,
  output logic [CSR_W-1:0]  tx_cur_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  localparam int NUM_PTR = 2;

  logic [IDX_W-1:0] idx;
  logic             unused_ofs;
  assign idx        = addr[OFS_LSB +: IDX_W];
  assign unused_ofs = ^addr[OFS_LSB-1:0];

  // write and read strobes per slot
  logic               wr_stat, wr_mode, rd_miss;
  logic [NUM_PTR-1:0] wr_ptr;

  always_comb begin
    wr_stat   = wr_en && (idx == IDX_W'(SLOT_STAT));
    wr_mode   = wr_en && (idx == IDX_W'(SLOT_MODE));
    rd_miss   = rd_en && (idx == IDX_W'(SLOT_MISS));
    wr_ptr[0] = wr_en && (idx == IDX_W'(SLOT_RXBASE));
    wr_ptr[1] = wr_en && (idx == IDX_W'(SLOT_TXBASE));
  end

  // descriptor list base / current pointers
  logic [CSR_W-1:0] base_q [NUM_PTR];
  logic [CSR_W-1:0] cur_q  [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    nic_ptr_reg #(.W(CSR_W)) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .ld     (wr_ptr[g]),
      .d      (wdata),
      .base_o (base_q[g]),
      .cur_o  (cur_q[g])
    );
  end

  assign rx_cur_o = cur_q[0];
  assign tx_cur_o = cur_q[1];

  // status word, summaries and interrupt
  logic [CSR_W-1:0] stat_w;
  logic             irq_w;

  nic_stat_unit u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_i),
    .clr_en   (wr_stat),
    .clr_data (wdata),
    .stat_o   (stat_w),
    .irq_o    (irq_w)
  );

  assign irq_o = irq_w;

  // missed-frame counter
  nic_miss_ctr #(.CNT_W(MISS_W)) u_miss (
    .clk   (clk),
    .rst   (rst),
    .inc   (miss_i),
    .clr   (rd_miss),
    .cnt_o (miss_cnt_o)
  );

  // operating mode register
  logic [CSR_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (wr_mode) mode_q <= wdata;
  end

  // read path
  logic [CSR_W-1:0] stat_rd, rd_mux, rdata_q;

  always_comb begin
    stat_rd = stat_w;
    stat_rd[TX_ST_LSB +: 3] = proc_state(mode_q[MODE_RUN_TX]);
    stat_rd[RX_ST_LSB +: 3] = proc_state(mode_q[MODE_RUN_RX]);
  end

  always_comb begin
    case (idx)
      IDX_W'(SLOT_RXBASE): rd_mux = base_q[0];
      IDX_W'(SLOT_TXBASE): rd_mux = base_q[1];
      IDX_W'(SLOT_STAT):   rd_mux = stat_rd;
      IDX_W'(SLOT_MODE):   rd_mux = mode_q;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
    else            rdata_q <= '0;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk
  import nic_csr_pkg::*;
#(
  parameter  int NUM_REGS = 16,
  parameter  int OFS_LSB  = 3,
  parameter  int MISS_W   = 16,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int ADDR_W   = IDX_W + OFS_LSB
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CSR_W-1:0]  wdata,
  input logic [CSR_W-1:0]  evt_i,
  input logic              miss_i,
  input logic              irq_o,
  input logic [CSR_W-1:0]  stat_v,
  input logic [CSR_W-1:0]  rx_cur_o,
  input logic [MISS_W-1:0] miss_cnt_o
);
  logic [IDX_W-1:0] idx;
  assign idx = addr[OFS_LSB +: IDX_W];

  p_evt_set_r2: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & EVT_MASK)) |=>
      ((stat_v & $past(evt_i) & EVT_MASK) == ($past(evt_i) & EVT_MASK)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && idx == IDX_W'(SLOT_STAT)) && (evt_i & EVT_MASK) == '0) |=>
      $stable(stat_v));

  p_nrm_sum_r3: assert property (@(posedge clk) disable iff (rst)
    stat_v[NRM_BIT] == (|(stat_v & NRM_MASK)));

  p_abn_sum_r4: assert property (@(posedge clk) disable iff (rst)
    stat_v[ABN_BIT] == (|(stat_v & ABN_MASK)));

  p_irq_level_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o == (stat_v[NRM_BIT] | stat_v[ABN_BIT]));

  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(SLOT_STAT) && (evt_i & wdata & EVT_MASK) == '0) |=>
      ((stat_v & $past(wdata) & EVT_MASK) == '0));

  p_miss_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == IDX_W'(SLOT_MISS) && !miss_i) |=> (miss_cnt_o == '0));

  p_rx_load_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(SLOT_RXBASE)) |=> (rx_cur_o == $past(wdata)));
endmodule

bind nic_csr_block nic_csr_chk #(
  .NUM_REGS (NUM_REGS),
  .OFS_LSB  (OFS_LSB),
  .MISS_W   (MISS_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .evt_i      (evt_i),
  .miss_i     (miss_i),
  .irq_o      (irq_o),
  .stat_v     (stat_w),
  .rx_cur_o   (rx_cur_o),
  .miss_cnt_o (miss_cnt_o)
);

// File: tb/nic_csr_block_tb.sv
module nic_csr_block_tb;
  localparam int MISS_W = 4;

  typedef struct packed {
    logic [31:0] evt;
    logic [31:0] clr;
    logic [31:0] exp;
  } vec_t;

  // event pulse, simultaneous clear data, expected status afterwards
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0001, 32'h0000_0000, 32'h0001_0001},
    '{32'h0000_2000, 32'h0000_0000, 32'h0001_A001},
    '{32'h0000_0000, 32'h0000_0001, 32'h0000_A000},
    '{32'h0000_5410, 32'h0000_0000, 32'h0000_A000},
    '{32'h0000_0080, 32'h0000_2000, 32'h0000_8080},
    '{32'h0000_0044, 32'h0001_8000, 32'h0001_80C4},
    '{32'h0000_0040, 32'h0000_0040, 32'h0001_80C4},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'h0000_2BEF, 32'h0000_0000, 32'h0001_ABEF},
    '{32'h0000_0000, 32'h0000_2BAA, 32'h0001_0045},
    '{32'h0000_0000, 32'h0000_0045, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] evt_i = '0;
  logic        miss_i = 1'b0;
  logic        irq_o;
  logic [31:0] rx_cur_o, tx_cur_o;
  logic [MISS_W-1:0] miss_cnt_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  nic_csr_block #(.MISS_W(MISS_W)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .evt_i      (evt_i),
    .miss_i     (miss_i),
    .irq_o      (irq_o),
    .rx_cur_o   (rx_cur_o),
    .tx_cur_o   (tx_cur_o),
    .miss_cnt_o (miss_cnt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [2:0] lo, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {idx, lo}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = {idx, 3'b000};
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 rx_cur", rx_cur_o, 32'h0);
    chk("R1 tx_cur", tx_cur_o, 32'h0);
    chk("R1 miss", {28'b0, miss_cnt_o}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd(4'd5, v);
    chk("R1 status", v, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evt_i = VEC[i].evt;
      if (VEC[i].clr != '0) begin
        wr_en = 1'b1; addr = {4'd5, 3'b000}; wdata = VEC[i].clr;
      end
      @(negedge clk);
      evt_i = '0; wr_en = 1'b0; wdata = '0;
      chk($sformatf("R5 irq step %0d", i), {31'b0, irq_o},
          {31'b0, (VEC[i].exp[16] | VEC[i].exp[15])});
      rd(4'd5, v);
      chk($sformatf("R2/R3/R4/R6/R7 status step %0d", i), v, VEC[i].exp);
    end

    // R8 process state fields
    wr(4'd6, 3'b000, 32'h0000_2000);
    rd(4'd5, v);
    chk("R8 tx state", v, 32'h0030_0000);
    wr(4'd6, 3'b000, 32'h0000_0002);
    rd(4'd5, v);
    chk("R8 rx state", v, 32'h0006_0000);
    wr(4'd6, 3'b000, 32'h0000_2002);
    rd(4'd5, v);
    chk("R8 both states", v, 32'h0036_0000);
    rd(4'd6, v);
    chk("R8 mode readback", v, 32'h0000_2002);
    wr(4'd6, 3'b000, 32'h0);

    // R10 descriptor bases
    wr(4'd3, 3'b000, 32'h1234_5678);
    chk("R10 rx_cur", rx_cur_o, 32'h1234_5678);
    wr(4'd4, 3'b000, 32'h0BAD_F00D);
    chk("R10 tx_cur", tx_cur_o, 32'h0BAD_F00D);
    chk("R10 rx_cur kept", rx_cur_o, 32'h1234_5678);
    rd(4'd4, v);
    chk("R10 tx base readback", v, 32'h0BAD_F00D);
    @(negedge clk);
    chk("R12 rdata idle zero", rdata, 32'h0);

    // R11 offset low bits ignored, unmapped slots inert
    wr(4'd3, 3'b101, 32'hA5A5_0000);
    chk("R11 low bits ignored", rx_cur_o, 32'hA5A5_0000);
    wr(4'd7, 3'b000, 32'hFFFF_FFFF);
    rd(4'd7, v);
    chk("R11 unmapped read", v, 32'h0);
    rd(4'd0, v);
    chk("R11 slot0 read", v, 32'h0);
    chk("R11 rx_cur untouched", rx_cur_o, 32'hA5A5_0000);
    rd(4'd5, v);
    chk("R11 status untouched", v, 32'h0);

    // R9 missed-frame counter
    @(negedge clk); miss_i = 1'b1;
    repeat (5) @(negedge clk);
    miss_i = 1'b0;
    chk("R9 count 5", {28'b0, miss_cnt_o}, 32'd5);
    rd(4'd8, v);
    chk("R9 read zero", v, 32'h0);
    chk("R9 cleared", {28'b0, miss_cnt_o}, 32'd0);
    @(negedge clk); miss_i = 1'b1;
    repeat (20) @(negedge clk);
    miss_i = 1'b0;
    chk("R9 saturate", {28'b0, miss_cnt_o}, 32'd15);
    @(negedge clk);
    rd_en = 1'b1; addr = {4'd8, 3'b000}; miss_i = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; miss_i = 1'b0;
    chk("R9 read with pulse", {28'b0, miss_cnt_o}, 32'd1);

    finish_run();
  end
endmodule